// File: doc/BRIEF.md
# Privilege-Checked Cycle Counter Snapshot Register

This block holds a 64-bit copy of a free-running cycle counter. Whenever the capture strobe is high, the block loads the counter value presented on that clock edge. Software reads the saved copy through a system-register read port. Each read carries a 16-bit register encoding and the privilege level (0 to 3) of the requester.

A read that carries this register's encoding passes through a fixed permission chain before any data comes back. The chain depends on the requester's level and on a set of configuration inputs:

- whether the feature and the 64-bit execution state exist;
- whether the top level is implemented, and its enable bits;
- the secure-debug undefined flags;
- whether the second level is enabled, along with its fine-grained read trap controls.

The result is one of three outcomes: success with data, undefined instruction, or a trap to level 2 or level 3 with a fixed syndrome class. A surrounding core uses the result to raise the matching exception. The check is combinational. The response is registered and appears exactly one cycle after the request.

Top module: `ccsnap_top`

## Requirements
- R1: After reset the snapshot is zero. When `cap_strobe` is high on a rising edge, the snapshot takes `cnt_value` from that edge. Otherwise the snapshot holds its value.
- R2: During reset and on the first cycle after it, `rsp_valid` is 0.
- R3: A response (`rsp_valid`=1) appears exactly one cycle after `rd_req`=1, and only when `rd_enc` equals 16'h875F. This value is the packing {op0=2'b10, op1=3'b000, CRn=4'b1110, CRm=4'b1011, op2=3'b111}, with op0 in the top bits. Any other encoding, or no request, gives `rsp_valid`=0.
- R4: If `cfg_snap_feat` or `cfg_wide_feat` is 0, every read reports undefined, at every level. The status codes are 2'b00 ok, 2'b01 undefined and 2'b10 trap.
- R5: With both features present, a read from level 0 reports undefined.
- R6: At level 1 the checks below apply in this order, and the first one that matches decides the result:
  - (a) undefined when `cfg_lvl3_exists`, `cfg_sdd_undef_prio` and !`cfg_lvl3_snap_en` all hold;
  - (b) trap to level 2 when `cfg_mid_enabled` and `cfg_fine_v2_impl` hold and either (`cfg_lvl3_exists` and !`cfg_lvl3_fine_en2`) or !`cfg_mid_snap_rd_ok`;
  - (c) when `cfg_lvl3_exists` and !`cfg_lvl3_snap_en` hold, undefined if `cfg_sdd_undef` is set and a trap to level 3 if it is not;
  - (d) otherwise ok.
- R7: At level 2 the same chain applies with step (b) skipped.
- R8: With both features present, a read from level 3 is always ok.
- R9: A trap reports status 2'b10, `rsp_syndrome`=6'h18 and `rsp_target` equal to the level it goes to (2 or 3). Ok and undefined responses report target 0 and syndrome 0.
- R10: `rsp_data` is zero unless the status is ok. An ok read returns the snapshot as it was before the request edge, so a capture on the same edge is not visible in that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_value | input | 64 | Live cycle counter value |
| cap_strobe | input | 1 | Capture event; loads the snapshot |
| rd_req | input | 1 | Read request |
| rd_enc | input | 16 | Packed register encoding {op0,op1,CRn,CRm,op2} |
| rd_level | input | 2 | Requester privilege level |
| cfg_snap_feat | input | 1 | Snapshot feature present |
| cfg_wide_feat | input | 1 | 64-bit execution state present |
| cfg_lvl3_exists | input | 1 | Level 3 implemented |
| cfg_sdd_undef_prio | input | 1 | Secure-debug undefined takes priority |
| cfg_sdd_undef | input | 1 | Secure-debug undefined instead of a level-3 trap |
| cfg_lvl3_snap_en | input | 1 | Level-3 enable for snapshot access |
| cfg_mid_enabled | input | 1 | Level 2 enabled |
| cfg_fine_v2_impl | input | 1 | Second-version fine-grained traps implemented |
| cfg_lvl3_fine_en2 | input | 1 | Level-3 enable for second-version fine-grained traps |
| cfg_mid_snap_rd_ok | input | 1 | Level-2 read control for snapshot data (0 traps) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_status | output | 2 | 00 ok, 01 undefined, 10 trap |
| rsp_target | output | 2 | Trap target level, 0 when not a trap |
| rsp_syndrome | output | 6 | Syndrome class, 6'h18 on a trap |
| rsp_data | output | 64 | Snapshot value on ok, zero otherwise |

## Verification
The bench goes after the following corner cases:

- **Priority between step (a) and step (b) at level 1.** A design that checked the level-2 trap first would trap to level 2 where undefined is due.
- **Skipping of step (b) at level 2.** A design that wrongly applied it would trap a level-2 read to itself.
- **Split of step (c) on the secure-debug flag.** A design that got this wrong would swap undefined and level-3 traps.
- **Feature-absent case at level 3.** This must still be undefined, and a design that put the level-3 shortcut first would return data.
- **Capture on the same edge as a read.** A design that forwarded the new value would return the newer count.
- **Wrong encodings.** A loose decoder would answer them.

// File: rtl/ccsnap_pkg.sv
package ccsnap_pkg;

    localparam int DATA_W  = 64;
    localparam int ENC_W   = 16;
    localparam int LVL_W   = 2;
    localparam int SYND_W  = 6;

    // packed {op0, op1, CRn, CRm, op2}
    localparam logic [ENC_W-1:0]  SNAP_ENC   = {2'b10, 3'b000, 4'b1110, 4'b1011, 3'b111};
    localparam logic [SYND_W-1:0] TRAP_CLASS = 6'h18;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_UNDEF = 2'b01,
        ST_TRAP  = 2'b10
    } status_e;

    typedef struct packed {
        logic snap_feat;
        logic wide_feat;
        logic lvl3_exists;
        logic sdd_undef_prio;
        logic sdd_undef;
        logic lvl3_snap_en;
        logic mid_enabled;
        logic fine_v2_impl;
        logic lvl3_fine_en2;
        logic mid_snap_rd_ok;
    } cfg_t;

    typedef struct packed {
        status_e          status;
        logic [LVL_W-1:0] target;
    } verdict_t;

    function automatic verdict_t v_ok();
        verdict_t v;
        v.status = ST_OK;
        v.target = '0;
        return v;
    endfunction

    function automatic verdict_t v_undef();
        verdict_t v;
        v.status = ST_UNDEF;
        v.target = '0;
        return v;
    endfunction

    function automatic verdict_t v_trap(input logic [LVL_W-1:0] lvl);
        verdict_t v;
        v.status = ST_TRAP;
        v.target = lvl;
        return v;
    endfunction

endpackage

// File: rtl/ccsnap_capture.sv
module ccsnap_capture
    import ccsnap_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] live,
    output logic [W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (strobe) begin
            held <= live;
        end
    end
endmodule

// File: rtl/ccsnap_gate.sv
module ccsnap_gate
    import ccsnap_pkg::*;
(
    input  logic             hit,
    input  logic [LVL_W-1:0] level,
    input  cfg_t             cfg,
    output logic             accept,
    output verdict_t         verdict
);
    logic feats_ok;
    logic prio_undef;
    logic mid_trap;
    logic top_block;

    always_comb begin
        feats_ok   = cfg.snap_feat & cfg.wide_feat;
        prio_undef = cfg.lvl3_exists & cfg.sdd_undef_prio & ~cfg.lvl3_snap_en;
        mid_trap   = cfg.mid_enabled & cfg.fine_v2_impl &
                     ((cfg.lvl3_exists & ~cfg.lvl3_fine_en2) | ~cfg.mid_snap_rd_ok);
        top_block  = cfg.lvl3_exists & ~cfg.lvl3_snap_en;
    end

    always_comb begin
        accept = hit;
        if (!feats_ok) begin
            verdict = v_undef();
        end else begin
            unique case (level)
                2'd0: verdict = v_undef();
                2'd1: begin
                    if (prio_undef)      verdict = v_undef();
                    else if (mid_trap)   verdict = v_trap(2'd2);
                    else if (top_block)  verdict = cfg.sdd_undef ? v_undef() : v_trap(2'd3);
                    else                 verdict = v_ok();
                end
                2'd2: begin
                    if (prio_undef)      verdict = v_undef();
                    else if (top_block)  verdict = cfg.sdd_undef ? v_undef() : v_trap(2'd3);
                    else                 verdict = v_ok();
                end
                default: verdict = v_ok();
            endcase
        end
    end
endmodule

// File: rtl/ccsnap_resp.sv
module ccsnap_resp
    import ccsnap_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  verdict_t          verdict,
    input  logic [W-1:0]      snap,
    output logic              valid,
    output logic [1:0]        status,
    output logic [LVL_W-1:0]  target,
    output logic [SYND_W-1:0] synd,
    output logic [W-1:0]      data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            status <= ST_OK;
            target <= '0;
            synd   <= '0;
            data   <= '0;
        end else begin
            valid  <= accept;
            status <= accept ? verdict.status : ST_OK;
            target <= accept ? verdict.target : '0;
            synd   <= (accept && verdict.status == ST_TRAP) ? TRAP_CLASS : '0;
            data   <= (accept && verdict.status == ST_OK) ? snap : '0;
        end
    end
endmodule

// File: rtl/ccsnap_top.sv
module ccsnap_top
    import ccsnap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       cnt_value,
    input  logic              cap_strobe,
    input  logic              rd_req,
    input  logic [15:0]       rd_enc,
    input  logic [1:0]        rd_level,
    input  logic              cfg_snap_feat,
    input  logic              cfg_wide_feat,
    input  logic              cfg_lvl3_exists,
    input  logic              cfg_sdd_undef_prio,
    input  logic              cfg_sdd_undef,
    input  logic              cfg_lvl3_snap_en,
    input  logic              cfg_mid_enabled,
    input  logic              cfg_fine_v2_impl,
    input  logic              cfg_lvl3_fine_en2,
    input  logic              cfg_mid_snap_rd_ok,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [1:0]        rsp_target,
    output logic [5:0]        rsp_syndrome,
    output logic [63:0]       rsp_data
);
    cfg_t            cfg;
    verdict_t        verdict;
    logic            hit;
    logic            accept;
    logic [DATA_W-1:0] snap_q;

    always_comb begin
        cfg.snap_feat      = cfg_snap_feat;
        cfg.wide_feat      = cfg_wide_feat;
        cfg.lvl3_exists    = cfg_lvl3_exists;
        cfg.sdd_undef_prio = cfg_sdd_undef_prio;
        cfg.sdd_undef      = cfg_sdd_undef;
        cfg.lvl3_snap_en   = cfg_lvl3_snap_en;
        cfg.mid_enabled    = cfg_mid_enabled;
        cfg.fine_v2_impl   = cfg_fine_v2_impl;
        cfg.lvl3_fine_en2  = cfg_lvl3_fine_en2;
        cfg.mid_snap_rd_ok = cfg_mid_snap_rd_ok;
        hit                = rd_req && (rd_enc == SNAP_ENC);
    end

    ccsnap_capture #(.W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .strobe (cap_strobe),
        .live   (cnt_value),
        .held   (snap_q)
    );

    ccsnap_gate u_gate (
        .hit     (hit),
        .level   (rd_level),
        .cfg     (cfg),
        .accept  (accept),
        .verdict (verdict)
    );

    ccsnap_resp #(.W(DATA_W)) u_resp (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .verdict(verdict),
        .snap   (snap_q),
        .valid  (rsp_valid),
        .status (rsp_status),
        .target (rsp_target),
        .synd   (rsp_syndrome),
        .data   (rsp_data)
    );
endmodule

// File: rtl/ccsnap_chk.sv
module ccsnap_chk
    import ccsnap_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [63:0] cnt_value,
    input logic        cap_strobe,
    input logic        rd_req,
    input logic [15:0] rd_enc,
    input logic [1:0]  rd_level,
    input logic        cfg_snap_feat,
    input logic        cfg_wide_feat,
    input logic        rsp_valid,
    input logic [1:0]  rsp_status,
    input logic [1:0]  rsp_target,
    input logic [5:0]  rsp_syndrome,
    input logic [63:0] rsp_data,
    input logic [63:0] snap_q
);
    logic match;
    assign match = rd_req && (rd_enc == SNAP_ENC);

    assert_capture_load_R1: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |=> snap_q == $past(cnt_value));

    assert_capture_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !cap_strobe |=> $stable(snap_q));

    assert_no_stray_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        !match |=> !rsp_valid);

    assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (rst)
        match |=> rsp_valid);

    assert_feat_absent_R4: assert property (@(posedge clk) disable iff (rst)
        (match && !(cfg_snap_feat && cfg_wide_feat)) |=> rsp_status == ST_UNDEF);

    assert_level0_undef_R5: assert property (@(posedge clk) disable iff (rst)
        (match && rd_level == 2'd0) |=> rsp_status == ST_UNDEF);

    assert_level3_ok_R8: assert property (@(posedge clk) disable iff (rst)
        (match && rd_level == 2'd3 && cfg_snap_feat && cfg_wide_feat) |=> rsp_status == ST_OK);

    assert_trap_fields_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_TRAP) |-> (rsp_syndrome == 6'h18 && rsp_target >= 2'd2));

    assert_nontrap_fields_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != ST_TRAP) |-> (rsp_syndrome == 6'h0 && rsp_target == 2'd0));

    assert_data_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_status != ST_OK) |-> rsp_data == 64'h0);

    assert_data_prior_R10: assert property (@(posedge clk) disable iff (rst)
        match |=> (rsp_status != ST_OK || rsp_data == $past(snap_q)));
endmodule

bind ccsnap_top ccsnap_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cnt_value     (cnt_value),
    .cap_strobe    (cap_strobe),
    .rd_req        (rd_req),
    .rd_enc        (rd_enc),
    .rd_level      (rd_level),
    .cfg_snap_feat (cfg_snap_feat),
    .cfg_wide_feat (cfg_wide_feat),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_target    (rsp_target),
    .rsp_syndrome  (rsp_syndrome),
    .rsp_data      (rsp_data),
    .snap_q        (snap_q)
);

// File: tb/tb_ccsnap_top.sv
module tb_ccsnap_top;
    localparam logic [15:0] ENC = 16'h875F;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] cnt_value;
    logic        cap_strobe, rd_req;
    logic [15:0] rd_enc;
    logic [1:0]  rd_level;
    logic        f_snap, f_wide, l3, sddp, sdd, en3, mid, v2, fen2, midok;
    logic        rsp_valid;
    logic [1:0]  rsp_status, rsp_target;
    logic [5:0]  rsp_syndrome;
    logic [63:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [63:0] model_snap;

    always #10 clk = ~clk;

    ccsnap_top dut (
        .clk(clk), .rst(rst), .cnt_value(cnt_value), .cap_strobe(cap_strobe),
        .rd_req(rd_req), .rd_enc(rd_enc), .rd_level(rd_level),
        .cfg_snap_feat(f_snap), .cfg_wide_feat(f_wide), .cfg_lvl3_exists(l3),
        .cfg_sdd_undef_prio(sddp), .cfg_sdd_undef(sdd), .cfg_lvl3_snap_en(en3),
        .cfg_mid_enabled(mid), .cfg_fine_v2_impl(v2), .cfg_lvl3_fine_en2(fen2),
        .cfg_mid_snap_rd_ok(midok),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_target(rsp_target),
        .rsp_syndrome(rsp_syndrome), .rsp_data(rsp_data)
    );

    // returns {status, target}; status 00 ok, 01 undef, 10 trap
    function automatic logic [3:0] expect_result();
        if (!(f_snap && f_wide))   return {2'b01, 2'd0};        // R4
        if (rd_level == 2'd0)      return {2'b01, 2'd0};        // R5
        if (rd_level == 2'd3)      return {2'b00, 2'd0};        // R8
        if (l3 && sddp && !en3)    return {2'b01, 2'd0};        // R6 / R7 step a
        if (rd_level == 2'd1 && mid && v2 && ((l3 && !fen2) || !midok))
                                   return {2'b10, 2'd2};        // R6 step b
        if (l3 && !en3)            return sdd ? {2'b01, 2'd0} : {2'b10, 2'd3};
        return {2'b00, 2'd0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [9:0] c);
        {f_snap, f_wide, l3, sddp, sdd, en3, mid, v2, fen2, midok} = c;
    endtask

    // drive at a negedge, then compare at the following negedge
    task automatic step(input logic req, input logic [15:0] enc, input logic [1:0] lvl,
                        input logic cap, input logic [63:0] cnt, input string tag);
        logic        hit;
        logic [3:0]  er;
        logic [63:0] edata;
        rd_req = req; rd_enc = enc; rd_level = lvl; cap_strobe = cap; cnt_value = cnt;
        hit   = req && (enc == ENC);
        er    = expect_result();
        edata = (hit && er[3:2] == 2'b00) ? model_snap : 64'h0;
        if (cap) model_snap = cnt;
        @(negedge clk);
        check({tag, " R3 valid"}, {63'h0, rsp_valid}, {63'h0, hit});
        if (hit) begin
            check({tag, " status"},      {62'h0, rsp_status}, {62'h0, er[3:2]});
            check({tag, " R9 target"},   {62'h0, rsp_target}, {62'h0, er[1:0]});
            check({tag, " R9 syndrome"}, {58'h0, rsp_syndrome},
                  (er[3:2] == 2'b10) ? 64'h18 : 64'h0);
            check({tag, " R10 data"},    rsp_data, edata);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rst = 1'b1;
        rd_req = 0; rd_enc = 0; rd_level = 0; cap_strobe = 0; cnt_value = 0;
        set_cfg(10'b11_0_0_0_1_0_0_1_1);
        model_snap = 64'h0;
        repeat (3) @(negedge clk);
        check("R2 valid in reset", {63'h0, rsp_valid}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 valid after reset", {63'h0, rsp_valid}, 64'h0);

        // R1 reset snapshot zero, level 3 read
        step(1, ENC, 2'd3, 0, 64'h0, "R1 reset snap R8");
        // R10 capture and read on same edge return old value
        step(1, ENC, 2'd3, 1, 64'hDEAD_BEEF_0000_1111, "R10 same-edge");
        step(1, ENC, 2'd3, 0, 64'h0, "R1 captured");
        // R3 wrong encoding and no request
        step(1, ENC ^ 16'h0001, 2'd3, 0, 64'h0, "R3 wrong enc");
        step(0, ENC, 2'd3, 0, 64'h0, "R3 no req");
        // R4 features absent at level 3
        set_cfg(10'b01_0_0_0_1_0_0_1_1);
        step(1, ENC, 2'd3, 0, 64'h0, "R4 level3");
        set_cfg(10'b10_0_0_0_1_0_0_1_1);
        step(1, ENC, 2'd1, 0, 64'h0, "R4 level1");
        // R5 level 0
        set_cfg(10'b11_0_0_0_1_0_0_1_1);
        step(1, ENC, 2'd0, 0, 64'h0, "R5 level0");
        // R6 step a beats step b
        set_cfg(10'b11_1_1_0_0_1_1_0_0);
        step(1, ENC, 2'd1, 0, 64'h0, "R6 a over b");
        // R6 step b trap to 2
        set_cfg(10'b11_1_0_0_1_1_1_1_0);
        step(1, ENC, 2'd1, 0, 64'h0, "R6 b trap2");
        // R7 step b skipped at level 2
        step(1, ENC, 2'd2, 0, 64'h0, "R7 skip b");
        // R6 step c both ways
        set_cfg(10'b11_1_0_0_0_0_0_1_1);
        step(1, ENC, 2'd1, 0, 64'h0, "R6 c trap3");
        set_cfg(10'b11_1_0_1_0_0_0_1_1);
        step(1, ENC, 2'd2, 0, 64'h0, "R7 c undef");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] enc;
            logic        req;
            set_cfg(($urandom % 4 == 0) ? 10'($urandom) : (10'($urandom) | 10'b11_0000_0000));
            req = ($urandom % 5) != 0;
            enc = ($urandom % 6 == 0) ? 16'($urandom) : ENC;
            step(req, enc, 2'($urandom), 1'($urandom), {$urandom, $urandom}, "R6 R7 R1 rand");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule